// File: doc/BRIEF.md
# Run-Length Command Stream Compressor

This block sits in front of the forward channel of a fast parallel-port transmitter. It takes a stream of bytes on a valid/ready input and produces a stream of tagged items on a valid/ready output. Each output item is an 8-bit value plus a flag that marks it as data or command. When compression is on, a stretch of identical bytes leaves the block as one run-count command followed by a single copy of the byte. The receiver repeats that byte (count + 1) times. A byte that does not repeat goes out as a plain data item. A separate valid/ready side input injects channel-address commands into the same output stream.

Commands use the top bit of the byte to tell their two kinds apart. With the top bit clear, the low seven bits hold the number of repeats minus one. With the top bit set, the low seven bits hold a channel address. Because a count holds at most 127, a longer stretch is cut into several count/byte pairs. An end-of-packet flag on the input closes the current run at once. When the compression enable is low, bytes pass through one for one.

Back-pressure rules:
- The output holds its item, unchanged, for as long as `out_ready` is low.
- Neither input is accepted while an item is waiting on the output.
- Input bytes and address requests are taken only on a cycle where valid and ready are both high.
- No byte is dropped or repeated.

Top module: `rlc_compressor`

## Requirements
- R1: After reset, `out_valid` is 0, and `in_ready` is 1 when no address request is present.
- R2: With `compress_en` = 1, a run of N identical bytes (2 ≤ N ≤ 128) is emitted as two items. The first is a command item (`out_is_data` = 0) whose value is N−1, with bit 7 = 0. The second is a data item (`out_is_data` = 1) carrying the byte.
- R3: With `compress_en` = 1, a byte that differs from both of its neighbours in the stream is emitted as one data item, with no command before it. A run-count command never carries the value 0.
- R4: A run longer than 128 bytes is split. Each full chunk of 128 bytes gives command 127 (0x7F) plus the byte. The remainder is coded by R2 or R3.
- R5: A byte accepted with `in_last` = 1 ends the current run at once, and its items are emitted without waiting for more input. The next byte starts a new run, even if it has the same value.
- R6: A channel address request is emitted as a command item with bit 7 = 1 and bits 6:0 equal to `chan_addr`. It is accepted only when no run is pending, so a run is never split by it. When both inputs are valid and no run is pending, the address request is taken first.
- R7: With `compress_en` = 0, each accepted byte is emitted unchanged as one data item. Equal bytes are not merged.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output item stays stable. Neither `in_ready` nor `chan_ready` is high while an item is waiting.
- R9: If `compress_en` falls while a run is pending, that run is emitted (by R2 or R3) before any raw byte is accepted.
- R10: A run-count command is always followed directly by the data item of its run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compress_en | input | 1 | 1 = run-length coding, 0 = raw pass-through |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when valid is high |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte ends its packet; flush the run |
| chan_valid | input | 1 | Channel address request valid |
| chan_ready | output | 1 | Address request accepted this cycle when valid is high |
| chan_addr | input | 7 | Channel address to send |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream takes the item this cycle |
| out_data | output | 8 | Output item value |
| out_is_data | output | 1 | 1 = data item, 0 = command item |

## Verification
Every output item comes straight from registers. An item appears in the cycle after the edge that accepts its cause: a raw byte, an address request, a byte that breaks a run, a byte flagged last, or a drop of the enable while a run is pending. The next item of a pair follows one cycle after the edge at which the previous item is taken. The bench therefore drives inputs and `out_ready` at the falling edge and samples one time unit later. It logs an item as transferred only when both `out_valid` and its own `out_ready` are high at that point, so the comparison against the expected stream does not depend on any cycle count. Stall stability is checked on every falling edge that follows a refused item.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [2:0] {
    ST_ACC  = 3'd0,  // collecting input, nothing on the output
    ST_CMD  = 3'd1,  // presenting a run-count command
    ST_DAT  = 3'd2,  // presenting the byte of a run
    ST_CHAN = 3'd3,  // presenting a channel address command
    ST_RAW  = 3'd4   // presenting a raw pass-through byte
  } rlc_state_e;
endpackage

// File: rtl/rlc_match.sv
module rlc_match #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W:0]   cur_byte,
  input  logic [CNT_W:0]   new_byte,
  input  logic [CNT_W-1:0] reps_m1,
  output logic             extend
);
  localparam logic [CNT_W-1:0] REPS_FULL = {CNT_W{1'b1}};

  // A new byte joins the run only if it matches and the count can still grow.
  assign extend = (new_byte == cur_byte) && (reps_m1 != REPS_FULL);
endmodule

// File: rtl/rlc_encode.sv
module rlc_encode
  import rlc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  rlc_state_e       state,
  input  logic [CNT_W-1:0] reps_m1,
  input  logic [CNT_W:0]   cur_byte,
  input  logic [CNT_W-1:0] chan_q,
  input  logic [CNT_W:0]   raw_q,
  output logic             item_valid,
  output logic [CNT_W:0]   item_data,
  output logic             item_is_data
);
  always_comb begin
    item_valid   = 1'b1;
    item_is_data = 1'b1;
    item_data    = cur_byte;
    unique case (state)
      ST_CMD: begin
        item_is_data = 1'b0;
        item_data    = {1'b0, reps_m1};
      end
      ST_CHAN: begin
        item_is_data = 1'b0;
        item_data    = {1'b1, chan_q};
      end
      ST_RAW:  item_data  = raw_q;
      ST_DAT:  item_data  = cur_byte;
      default: item_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/rlc_compressor.sv
module rlc_compressor
  import rlc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compress_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W:0]   in_data,
  input  logic             in_last,
  input  logic             chan_valid,
  output logic             chan_ready,
  input  logic [CNT_W-1:0] chan_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W:0]   out_data,
  output logic             out_is_data
);
  localparam int          BYTE_W  = CNT_W + 1;
  localparam logic [CNT_W-1:0] REPS_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] REPS_ZERO = '0;

  rlc_state_e        state;
  logic [BYTE_W-1:0] cur_byte, nxt_byte, raw_q;
  logic [CNT_W-1:0]  reps_m1, chan_q;
  logic              have_run, nxt_pend, nxt_last;
  logic              extend, in_fire, chan_fire;
  rlc_state_e        flush_st;

  rlc_match #(.CNT_W(CNT_W)) u_match (
    .cur_byte (cur_byte),
    .new_byte (in_data),
    .reps_m1  (reps_m1),
    .extend   (extend)
  );

  rlc_encode #(.CNT_W(CNT_W)) u_encode (
    .state        (state),
    .reps_m1      (reps_m1),
    .cur_byte     (cur_byte),
    .chan_q       (chan_q),
    .raw_q        (raw_q),
    .item_valid   (out_valid),
    .item_data    (out_data),
    .item_is_data (out_is_data)
  );

  // An address waits for the end of a run. A pending run must leave before raw bytes.
  assign chan_ready = (state == ST_ACC) && chan_valid && !have_run;
  assign in_ready   = (state == ST_ACC) && !(chan_valid && !have_run)
                      && !(have_run && !compress_en);
  assign in_fire    = in_valid && in_ready;
  assign chan_fire  = chan_valid && chan_ready;
  // A lone byte skips the count command.
  assign flush_st   = (reps_m1 == REPS_ZERO) ? ST_DAT : ST_CMD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ACC;
      cur_byte <= '0;
      nxt_byte <= '0;
      raw_q    <= '0;
      reps_m1  <= '0;
      chan_q   <= '0;
      have_run <= 1'b0;
      nxt_pend <= 1'b0;
      nxt_last <= 1'b0;
    end else begin
      unique case (state)
        ST_ACC: begin
          if (chan_fire) begin
            chan_q <= chan_addr;
            state  <= ST_CHAN;
          end else if (in_fire) begin
            if (!compress_en) begin
              raw_q <= in_data;
              state <= ST_RAW;
            end else if (!have_run) begin
              cur_byte <= in_data;
              reps_m1  <= REPS_ZERO;
              have_run <= 1'b1;
              if (in_last) state <= ST_DAT;
            end else if (extend) begin
              reps_m1 <= reps_m1 + REPS_ONE;
              if (in_last) state <= ST_CMD;
            end else begin
              nxt_byte <= in_data;
              nxt_last <= in_last;
              nxt_pend <= 1'b1;
              state    <= flush_st;
            end
          end else if (have_run && !compress_en) begin
            state <= flush_st;
          end
        end
        ST_CMD: if (out_ready) state <= ST_DAT;
        ST_DAT: begin
          if (out_ready) begin
            if (nxt_pend) begin
              cur_byte <= nxt_byte;
              reps_m1  <= REPS_ZERO;
              nxt_pend <= 1'b0;
              state    <= nxt_last ? ST_DAT : ST_ACC;
            end else begin
              have_run <= 1'b0;
              state    <= ST_ACC;
            end
          end
        end
        ST_CHAN, ST_RAW: if (out_ready) state <= ST_ACC;
        default: state <= ST_ACC;
      endcase
    end
  end

  // R8: a refused item holds still
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_data));
  // R8: nothing enters while an item waits
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready && !chan_ready);
  // R3: a count command never carries zero
  assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_data && !out_data[CNT_W] |-> out_data[CNT_W-1:0] != '0);
  // R10: a count command is followed directly by its data byte
  assert_count_then_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_is_data && !out_data[CNT_W] |=> out_valid && out_is_data);
  // R6: an accepted address appears next as a marked command
  assert_chan_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_valid && chan_ready |=> out_valid && !out_is_data && out_data[CNT_W]
                                 && out_data[CNT_W-1:0] == $past(chan_addr));
  // R7: a raw byte appears next, unchanged
  assert_raw_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !compress_en |=> out_valid && out_is_data
                                             && out_data == $past(in_data));
endmodule

// File: tb/sim_rlc_compressor.sv
`timescale 1ns/1ps
module sim_rlc_compressor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       compress_en = 1'b1;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       chan_valid = 1'b0;
  logic [6:0] chan_addr = '0;
  logic       chan_ready;
  logic       out_valid, out_is_data;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  always #10 clk = ~clk;  // 50 MHz

  rlc_compressor u0 (
    .clk(clk), .rst_n(rst_n), .compress_en(compress_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .chan_valid(chan_valid), .chan_ready(chan_ready), .chan_addr(chan_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_data(out_is_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  logic [8:0] exp_q[$];
  logic stall_en = 1'b0;
  logic stalled = 1'b0;
  logic [8:0] held = '0;

  // Stimulus {en, last, byte}. Expected {is_data, value}; is_data=0 marks a command.
  localparam int NS = 14;
  localparam int NE = 13;
  localparam logic [9:0] STIM [NS] = '{
    {2'b10, 8'h41}, {2'b10, 8'h41}, {2'b10, 8'h41}, // run of 3 (R2)
    {2'b10, 8'h42},                                 // lone byte (R3)
    {2'b10, 8'h43}, {2'b11, 8'h43},                 // run closed by last (R5)
    {2'b10, 8'h43}, {2'b11, 8'h44},                 // equal byte after last starts anew (R5)
    {2'b00, 8'h55}, {2'b00, 8'h55},                 // raw, not merged (R7)
    {2'b10, 8'h66}, {2'b10, 8'h66},                 // run pending ...
    {2'b00, 8'h77},                                 // ... flushed when enable drops (R9)
    {2'b11, 8'h00}
  };
  localparam logic [8:0] EXPV [NE] = '{
    {1'b0, 8'h02}, {1'b1, 8'h41}, {1'b1, 8'h42}, {1'b0, 8'h01}, {1'b1, 8'h43},
    {1'b1, 8'h43}, {1'b1, 8'h44}, {1'b1, 8'h55}, {1'b1, 8'h55}, {1'b0, 8'h01},
    {1'b1, 8'h66}, {1'b1, 8'h77}, {1'b1, 8'h00}
  };  // count followed by its byte throughout (R10)

  task automatic check(input string req, input logic ok, input logic [8:0] act,
                       input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Consumer: drives out_ready at the falling edge, logs the transfers of the next rising edge
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
    #1;
    if (rst_n) begin
      if (stalled)
        check("R8", out_valid && {out_is_data, out_data} == held,
              {out_is_data, out_data}, held);
      if (out_valid && out_ready) begin
        stalled = 1'b0;
        if (exp_q.size() == 0)
          check(cur_req, 1'b0, {out_is_data, out_data}, 9'h1ff);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(cur_req, {out_is_data, out_data} == e, {out_is_data, out_data}, e);
        end
      end else if (out_valid) begin
        stalled = 1'b1;
        held = {out_is_data, out_data};
      end else stalled = 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) if (cyc > 100000) begin
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic push(input logic en, input logic last, input logic [7:0] b);
    @(negedge clk);
    compress_en = en; in_last = last; in_data = b; in_valid = 1'b1;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", !out_valid, {8'h0, out_valid}, 9'h0);
    @(negedge clk); rst_n = 1'b1; #2;
    check("R1", !out_valid && in_ready, {7'h0, out_valid, in_ready}, 9'h1);

    // Vector table walked with stalls on the output
    cur_req = "R2/R3/R5/R7/R9/R10";
    stall_en = 1'b1;
    for (int i = 0; i < NE; i++) exp_q.push_back(EXPV[i]);
    for (int i = 0; i < NS; i++) push(STIM[i][9], STIM[i][8], STIM[i][7:0]);
    drain();

    // R4: 300 equal bytes split into 128 + 128 + 44
    cur_req = "R4";
    exp_q.push_back(9'h07f); exp_q.push_back(9'h15a);
    exp_q.push_back(9'h07f); exp_q.push_back(9'h15a);
    exp_q.push_back(9'h02b); exp_q.push_back(9'h15a);
    for (int i = 0; i < 300; i++) push(1'b1, i == 299, 8'h5a);
    drain();

    // R6: address while idle, then an address held off by a pending run
    cur_req = "R6";
    stall_en = 1'b0;
    exp_q.push_back(9'h095);
    @(negedge clk); chan_addr = 7'h15; chan_valid = 1'b1; #2;
    while (!chan_ready) begin @(negedge clk); #2; end
    @(negedge clk); chan_valid = 1'b0;
    drain();

    exp_q.push_back(9'h001); exp_q.push_back(9'h111);
    exp_q.push_back(9'h122); exp_q.push_back(9'h083);
    push(1'b1, 1'b0, 8'h11);
    push(1'b1, 1'b0, 8'h11);
    @(negedge clk); in_valid = 1'b0; chan_addr = 7'h03; chan_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #2;
      check("R6", !chan_ready && !out_valid, {7'h0, chan_ready, out_valid}, 9'h0);
      @(negedge clk);
    end
    push(1'b1, 1'b1, 8'h22);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; #2;
    while (!chan_ready) begin @(negedge clk); #2; end
    @(negedge clk); chan_valid = 1'b0;
    drain();

    summary();
  end
endmodule